// File: doc/BRIEF.md
# Digital Potentiometer Wiper Position Register

This block keeps the wiper position of one digitally controlled potentiometer. The position is a volatile register, 6 bits wide by default. It is decoded into one enable line for each of the 64 tap switches, and exactly one of those lines is high at any time. The analog resistor chain sits outside the block and uses only these enables.

The position can change in four ways:

- **Reset.** It takes the value recalled from the first nonvolatile data register.
- **Host write.** The host can write it directly.
- **Transfer.** It can be loaded from any of the four data registers.
- **Stepping mode.** It can move one tap at a time. The serial front end arms this mode once the increment/decrement instruction has been acknowledged. After that, every serial clock high pulse moves the wiper one tap. The data line level during the pulse sets the direction. A start or stop condition on the serial lines ends the mode and does not count as a step.

The serial clock and data inputs are expected to be already synchronized to `clk`. The block samples them and detects their edges itself.

Top module: `wiper_step_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `wiper` equals `recall_val`, `tap_en` has only bit `recall_val` set, and `step_mode` is 0.
- R2: `tap_en` always has exactly one bit set, at the index equal to `wiper` (bit 0 is the low terminal, bit 63 the high terminal).
- R3: A cycle with `load_en` high makes `wiper` equal `load_val` from the next cycle on. This takes priority over a transfer and over a step in the same cycle.
- R4: A cycle with `xfer_en` high and `load_en` low copies data register `dr_sel` into `wiper`. Register k occupies bits [6k+5:6k] of `dr_vals`.
- R5: Serial clock pulses have no effect on `wiper` until `step_mode` has been set by a one-cycle `step_arm` pulse.
- R6: In stepping mode, a `scl` high pulse with `sda` high moves `wiper` up by one, and with `sda` low moves it down by one. The change is visible the cycle after `scl` is sampled low again.
- R7: Stepping saturates: up at 63 leaves 63, down at 0 leaves 0, and there is no wraparound.
- R8: A change of `sda` while `scl` is high (a start or stop) clears `step_mode` and causes no step. Later pulses are then ignored until the mode is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, several times faster than `scl` |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_val | input | 6 | Position recalled from data register 0, loaded at reset |
| load_en | input | 1 | Host write strobe for the position |
| load_val | input | 6 | Position written by the host |
| xfer_en | input | 1 | Load position from the selected data register |
| dr_sel | input | 2 | Data register index for a transfer |
| dr_vals | input | 24 | The four data register values, register k at bits [6k+5:6k] |
| step_arm | input | 1 | One-cycle pulse: increment/decrement instruction acknowledged |
| scl | input | 1 | Synchronized serial clock level |
| sda | input | 1 | Synchronized serial data level |
| wiper | output | 6 | Current wiper position |
| tap_en | output | 64 | One-hot tap switch enables |
| step_mode | output | 1 | Stepping mode active |

## Verification
The assertions check on every cycle that a host write or transfer lands the following cycle, and that the position never moves while stepping mode is off. They also check that an unforced change is at most one tap and never wraps between 0 and 63, and that an SDA change during SCL high leaves stepping mode off. Only the bench scenarios can show the following:
- the reset recall value;
- the decoded one-hot pattern for every position;
- the direction chosen by the data level;
- saturation after repeated pulses;
- that pulses after a start condition leave the position unchanged.

// File: rtl/wiper_step_reg.sv
module wiper_step_reg #(
  parameter int WIDTH  = 6,
  parameter int NUM_DR = 4,
  localparam int TAPS  = 1 << WIDTH,
  localparam int SELW  = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        recall_val,
  input  logic                    load_en,
  input  logic [WIDTH-1:0]        load_val,
  input  logic                    xfer_en,
  input  logic [SELW-1:0]         dr_sel,
  input  logic [NUM_DR*WIDTH-1:0] dr_vals,
  input  logic                    step_arm,
  input  logic                    scl,
  input  logic                    sda,
  output logic [WIDTH-1:0]        wiper,
  output logic [TAPS-1:0]         tap_en,
  output logic                    step_mode
);

  localparam logic [WIDTH-1:0] POS_MAX = '1;

  logic scl_q, sda_q, dir_up;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire bus_cond = scl & scl_q & (sda ^ sda_q);
  wire step_now = step_mode & scl_fall;
  wire [WIDTH-1:0] dr_pick = dr_vals[dr_sel*WIDTH +: WIDTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      dir_up    <= 1'b0;
      step_mode <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (scl_rise) dir_up <= sda;
      if (step_arm)      step_mode <= 1'b1;
      else if (bus_cond) step_mode <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wiper <= recall_val;
    else if (load_en)
      wiper <= load_val;
    else if (xfer_en)
      wiper <= dr_pick;
    else if (step_now) begin
      if (dir_up && wiper != POS_MAX) wiper <= wiper + 1'b1;
      else if (!dir_up && wiper != '0) wiper <= wiper - 1'b1;
    end
  end

  assign tap_en = TAPS'(1) << wiper;

  AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> wiper == $past(load_val));  // R3
  AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !load_en) |=> wiper == $past(dr_pick));  // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_mode && !load_en && !xfer_en) |=> $stable(wiper));  // R5
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !xfer_en) |=> (wiper == $past(wiper) ||
      wiper == $past(wiper) + WIDTH'(1) || wiper == $past(wiper) - WIDTH'(1)));  // R6
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !xfer_en && wiper == POS_MAX) |=> wiper != '0);  // R7
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !xfer_en && wiper == '0) |=> wiper != POS_MAX);  // R7
  AST_COND_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cond && !step_arm) |=> !step_mode);  // R8

endmodule

// File: tb/wiper_step_reg_tb_top.sv
module wiper_step_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] recall_val = 6'd37;
  logic load_en = 1'b0, xfer_en = 1'b0, step_arm = 1'b0, scl = 1'b0, sda = 1'b0;
  logic [5:0] load_val = '0;
  logic [1:0] dr_sel = '0;
  logic [23:0] dr_vals = {6'd50, 6'd9, 6'd63, 6'd4};
  logic [5:0] wiper;
  logic [63:0] tap_en;
  logic step_mode;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wiper_step_reg dut_i (
    .clk(clk), .rst_n(rst_n), .recall_val(recall_val), .load_en(load_en),
    .load_val(load_val), .xfer_en(xfer_en), .dr_sel(dr_sel), .dr_vals(dr_vals),
    .step_arm(step_arm), .scl(scl), .sda(sda), .wiper(wiper), .tap_en(tap_en),
    .step_mode(step_mode));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_load(input logic [5:0] v);
    @(negedge clk) begin load_en = 1'b1; load_val = v; end
    @(negedge clk) load_en = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk) step_arm = 1'b1;
    @(negedge clk) step_arm = 1'b0;
  endtask

  task automatic pulse(input logic d);
    @(negedge clk) sda = d;
    @(negedge clk) scl = 1'b1;
    @(negedge clk);
    @(negedge clk) scl = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 wiper in reset", 64'(wiper), 64'd37);
    @(negedge clk) rst_n = 1'b1;
    check("R1 wiper after reset", 64'(wiper), 64'd37);
    check("R1 tap after reset", tap_en, 64'd1 << 37);
    check("R1 mode after reset", 64'(step_mode), 64'd0);
  endtask

  task automatic t_decode();
    for (int i = 0; i < 64; i++) begin
      host_load(6'(i));
      check("R2 one-hot count", 64'($countones(tap_en)), 64'd1);
      check("R2 one-hot index", tap_en, 64'd1 << i);
    end
  endtask

  task automatic t_load_priority();
    @(negedge clk) begin load_en = 1'b1; load_val = 6'd21; xfer_en = 1'b1; dr_sel = 2'd1; end
    @(negedge clk) begin load_en = 1'b0; xfer_en = 1'b0; end
    check("R3 load beats transfer", 64'(wiper), 64'd21);
  endtask

  task automatic t_xfer();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) begin xfer_en = 1'b1; dr_sel = 2'(k); end
      @(negedge clk) xfer_en = 1'b0;
      check("R4 transfer", 64'(wiper), 64'(dr_vals[k*6 +: 6]));
    end
  endtask

  task automatic t_idle_pulses();
    host_load(6'd30);
    pulse(1'b1);
    pulse(1'b0);
    pulse(1'b1);
    check("R5 pulses before arm ignored", 64'(wiper), 64'd30);
    check("R5 mode still off", 64'(step_mode), 64'd0);
  endtask

  task automatic t_step();
    host_load(6'd30);
    arm();
    check("R5 mode armed", 64'(step_mode), 64'd1);
    pulse(1'b1);
    check("R6 step up", 64'(wiper), 64'd31);
    pulse(1'b1);
    check("R6 second step up", 64'(wiper), 64'd32);
    pulse(1'b0);
    check("R6 step down", 64'(wiper), 64'd31);
    check("R6 tap follows", tap_en, 64'd1 << 31);
  endtask

  task automatic t_saturate();
    host_load(6'd62);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    check("R7 saturate high", 64'(wiper), 64'd63);
    host_load(6'd1);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    check("R7 saturate low", 64'(wiper), 64'd0);
  endtask

  task automatic t_cond_exit();
    host_load(6'd10);
    @(negedge clk) begin sda = 1'b1; scl = 1'b1; end
    @(negedge clk) sda = 1'b0;
    @(negedge clk) scl = 1'b0;
    @(negedge clk);
    check("R8 start ends mode", 64'(step_mode), 64'd0);
    check("R8 start not a step", 64'(wiper), 64'd10);
    pulse(1'b1);
    check("R8 pulse after start ignored", 64'(wiper), 64'd10);
    arm();
    @(negedge clk) begin sda = 1'b0; scl = 1'b1; end
    @(negedge clk) sda = 1'b1;
    @(negedge clk) scl = 1'b0;
    @(negedge clk);
    check("R8 stop ends mode", 64'(step_mode), 64'd0);
    check("R8 stop not a step", 64'(wiper), 64'd10);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_load_priority();
    t_xfer();
    t_idle_pulses();
    t_step();
    t_saturate();
    t_cond_exit();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule